// File: doc/BRIEF.md
# 32-bit Integer ALU with Condition Flags

This block executes one two-operand integer instruction per accepted cycle: addition, subtraction, comparison, bitwise AND, bitwise OR or bitwise XOR. One operand comes from a register and the other from a register-or-memory slot. The operation and the operand direction both come from a one-byte primary opcode. The block also produces the four condition flags: sign, zero, carry and signed overflow.

The decode and arithmetic are combinational. All outputs are registered, so a result appears one clock after the opcode is presented with `in_valid` high. The surrounding core fetches the opcode, supplies both operand values, and then uses `wr_en` and `dst_is_reg` to route `result` back to either the register file or memory. Opcodes outside the supported set raise `illegal` and change nothing downstream.

Top module: `alu32_flags`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first accepted opcode, `out_valid`, `wr_en`, `dst_is_reg`, `flags_en`, `illegal`, `result` and `flags` are all zero.
- R2: Opcodes 0x01 and 0x03 add the two operands modulo 2^32. Flag bit 1 (carry) is set exactly when the unsigned sum does not fit in 32 bits.
- R3: Opcodes 0x29 and 0x2b subtract the source from the destination operand modulo 2^32. Flag bit 1 (carry) is set exactly when an unsigned borrow occurs. For example, 0 minus 1 gives 0xffffffff with carry and sign set.
- R4: Opcode bit 1 sets the direction. When it is clear, the r/m operand is the destination and left operand, and `dst_is_reg` is 0. When it is set, the register is the destination and left operand, and `dst_is_reg` is 1.
- R5: Flag bit 3 (sign) equals bit 31 of the computed value. Flag bit 2 (zero) is set exactly when all 32 bits of the computed value are zero.
- R6: Flag bit 0 (overflow) is set exactly when the true signed result of an add or subtract differs from the 32-bit value. For example, 0x7fffffff + 1 gives flags SF=1, ZF=0, CF=0, OF=1, and 0x80000000 + 0x80000000 gives 0 with ZF=1, CF=1, OF=1.
- R7: Opcodes 0x21/0x23 (AND), 0x09/0x0b (OR) and 0x31/0x33 (XOR) always clear the carry and overflow flags.
- R8: Opcodes 0x39 and 0x3b compute destination minus source for the flags only. `flags_en` is 1 and `wr_en` is 0. For example, register 1 compared with 0xffffffff under 0x3b gives CF=1, SF=0, OF=0.
- R9: Any other opcode sets `illegal` and keeps `wr_en`, `flags_en` and `flags` at zero.
- R10: Each output reflects the opcode accepted on the previous clock edge. `out_valid` is `in_valid` delayed by one cycle, and a cycle with `in_valid` low produces no write, no flag update and no `illegal`.
- R11: The logical operations write the bitwise AND, OR or XOR of the two operands, with `wr_en` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode and operands are presented this cycle |
| opcode | input | 8 | Primary opcode byte |
| reg_val | input | 32 | Register operand |
| rm_val | input | 32 | Register-or-memory operand |
| out_valid | output | 1 | Outputs carry an accepted opcode |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Write `result` to its destination |
| dst_is_reg | output | 1 | 1: destination is the register, 0: the r/m slot |
| flags_en | output | 1 | Update the condition flags from `flags` |
| flags | output | 4 | {SF, ZF, CF, OF} |
| illegal | output | 1 | Opcode not supported |

## Verification
The arithmetic opcodes are exercised with four operand patterns: plain operands, operands that give unsigned wrap only, operands that give signed wrap only, and operands that give both. This separates the carry logic from the overflow logic and exposes a swapped or merged flag. Subtract and compare are run in both directions with asymmetric operands, so an operand swap changes the value or the borrow. The logical operations follow a carry-producing add, and AND, OR and XOR use distinct bit patterns, so a leftover flag or a wrong operator is detected. Unsupported opcodes that differ from legal ones in a single bit, together with idle cycles, check that nothing is written and that no flags are updated.

// File: rtl/alu32_flags.sv
module alu32_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [7:0]   opcode,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] rm_val,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         dst_is_reg,
  output logic         flags_en,
  output logic [3:0]   flags,
  output logic         illegal
);
  localparam int MSB = W - 1;

  logic [2:0] grp;
  logic       shape_ok, dir;
  logic       is_add, is_sub, is_and, is_or, is_xor, is_cmp, legal, take;
  logic [W-1:0] lhs, rhs, res_c;
  logic [W:0]   sum_x, diff_x;
  logic         cf_c, of_c;

  assign grp      = opcode[5:3];
  assign shape_ok = opcode[0] & ~opcode[2] & (opcode[7:6] == 2'b00);
  assign is_add   = shape_ok & (grp == 3'b000);
  assign is_or    = shape_ok & (grp == 3'b001);
  assign is_and   = shape_ok & (grp == 3'b100);
  assign is_sub   = shape_ok & (grp == 3'b101);
  assign is_xor   = shape_ok & (grp == 3'b110);
  assign is_cmp   = shape_ok & (grp == 3'b111);
  assign legal    = is_add | is_or | is_and | is_sub | is_xor | is_cmp;
  assign take     = in_valid & legal;

  assign dir = opcode[1];
  assign lhs = dir ? reg_val : rm_val;
  assign rhs = dir ? rm_val  : reg_val;

  assign sum_x  = {1'b0, lhs} + {1'b0, rhs};
  assign diff_x = {1'b0, lhs} - {1'b0, rhs};

  always_comb begin
    res_c = '0;
    cf_c  = 1'b0;
    of_c  = 1'b0;
    if (is_add) begin
      res_c = sum_x[MSB:0];
      cf_c  = sum_x[W];
      of_c  = (lhs[MSB] == rhs[MSB]) & (sum_x[MSB] != lhs[MSB]);
    end else if (is_sub | is_cmp) begin
      res_c = diff_x[MSB:0];
      cf_c  = diff_x[W];
      of_c  = (lhs[MSB] != rhs[MSB]) & (diff_x[MSB] != lhs[MSB]);
    end else if (is_and) begin
      res_c = lhs & rhs;
    end else if (is_or) begin
      res_c = lhs | rhs;
    end else if (is_xor) begin
      res_c = lhs ^ rhs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      wr_en      <= 1'b0;
      dst_is_reg <= 1'b0;
      flags_en   <= 1'b0;
      flags      <= '0;
      illegal    <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      result     <= take ? res_c : '0;
      wr_en      <= take & ~is_cmp;
      dst_is_reg <= in_valid & dir;
      flags_en   <= take;
      flags      <= take ? {res_c[MSB], ~|res_c, cf_c, of_c} : 4'b0000;
      illegal    <= in_valid & ~legal;
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wr_en && !flags_en && !illegal);

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en && !flags_en && flags == 4'b0000);

  // R5
  sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> flags[3] == result[MSB] && flags[2] == (result == '0));

  // R7
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (is_and || is_or || is_xor) |=> flags[1:0] == 2'b00);

  // R8
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_cmp |=> flags_en && !wr_en);

  // R2
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_add |=> flags[1] == (result < $past(reg_val)));

  // R3
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_sub |=> flags[1] == ($past(opcode[1]) ?
      ($past(reg_val) < $past(rm_val)) : ($past(rm_val) < $past(reg_val))));

  // R4
  dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dst_is_reg == $past(opcode[1]));
endmodule

// File: tb/sim_alu32_flags.sv
module sim_alu32_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [31:0] reg_val = '0;
  logic [31:0] rm_val = '0;
  logic        out_valid, wr_en, dst_is_reg, flags_en, illegal;
  logic [31:0] result;
  logic [3:0]  flags;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alu32_flags #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .reg_val(reg_val), .rm_val(rm_val), .out_valid(out_valid),
    .result(result), .wr_en(wr_en), .dst_is_reg(dst_is_reg),
    .flags_en(flags_en), .flags(flags), .illegal(illegal)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [31:0] r, input logic [31:0] m);
    @(negedge clk);
    opcode = op; reg_val = r; rm_val = m; in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic run_wr(input string req, input logic [7:0] op, input logic [31:0] r,
                        input logic [31:0] m, input logic [31:0] exp_res,
                        input logic [3:0] exp_flags);
    apply(op, r, m);
    chk(req, "result", result, exp_res);
    chk(req, "flags", flags, exp_flags);
    chk(req, "wr_en/flags_en/illegal", {wr_en, flags_en, illegal}, 3'b110);
    chk(req, "dst_is_reg", dst_is_reg, op[1]);
  endtask

  task automatic run_cmp(input string req, input logic [7:0] op, input logic [31:0] r,
                         input logic [31:0] m, input logic [3:0] exp_flags);
    apply(op, r, m);
    chk(req, "flags", flags, exp_flags);
    chk(req, "wr_en/flags_en/illegal", {wr_en, flags_en, illegal}, 3'b010);
  endtask

  task automatic t_reset;
    chk("R1", "outputs at reset",
        {out_valid, wr_en, dst_is_reg, flags_en, illegal, result, flags}, '0);
  endtask

  task automatic t_add;
    run_wr("R2 R4", 8'h03, 32'h10, 32'h1, 32'h11, 4'b0000);
    run_wr("R2 R4", 8'h01, 32'hffffffff, 32'h1, 32'h0, 4'b0110);
    run_wr("R6 R5", 8'h03, 32'h7fffffff, 32'h1, 32'h80000000, 4'b1001);
    run_wr("R6", 8'h01, 32'h80000000, 32'h80000000, 32'h0, 4'b0111);
  endtask

  task automatic t_sub;
    run_wr("R3 R4", 8'h29, 32'h1, 32'ha, 32'h9, 4'b0000);
    run_wr("R3 R4", 8'h2b, 32'ha, 32'h1, 32'h9, 4'b0000);
    run_wr("R3", 8'h2b, 32'h0, 32'h1, 32'hffffffff, 4'b1010);
    run_wr("R6", 8'h2b, 32'h80000000, 32'h7fffffff, 32'h1, 4'b0001);
    run_wr("R6", 8'h2b, 32'h0, 32'h80000000, 32'h80000000, 4'b1011);
  endtask

  task automatic t_logic;
    run_wr("R2", 8'h01, 32'hffffffff, 32'hffffffff, 32'hfffffffe, 4'b1010);
    run_wr("R7 R11", 8'h23, 32'h0a0b0c0d, 32'hff, 32'h0d, 4'b0000);
    run_wr("R7 R11", 8'h0b, 32'ha0b0c0d0, 32'h0a0b0c0d, 32'haabbccdd, 4'b1000);
    run_wr("R7 R11", 8'h31, 32'ha0b0c0d0, 32'haabb0c0d, 32'h0a0bccdd, 4'b0000);
    run_wr("R7 R5", 8'h33, 32'h5, 32'h5, 32'h0, 4'b0100);
    run_wr("R11", 8'h21, 32'hf0f0f0f0, 32'h3c3c3c3c, 32'h30303030, 4'b0000);
  endtask

  task automatic t_cmp;
    run_cmp("R8", 8'h3b, 32'h1, 32'hffffffff, 4'b0010);
    run_cmp("R8 R4", 8'h39, 32'h0a0b0c07, 32'h0a0b0c0d, 4'b0000);
    run_cmp("R8 R4", 8'h3b, 32'h0a0b0c07, 32'h0a0b0c0d, 4'b1010);
    run_cmp("R8", 8'h3b, 32'h0a0b0c0d, 32'h0a0b0c0d, 4'b0100);
    run_cmp("R8 R6", 8'h3b, 32'h7fffffff, 32'h80000000, 4'b1011);
  endtask

  task automatic t_illegal;
    logic [7:0] bad [4] = '{8'h11, 8'h05, 8'h02, 8'hff};
    foreach (bad[i]) begin
      apply(bad[i], 32'h1, 32'h1);
      chk("R9", "illegal/wr_en/flags_en", {illegal, wr_en, flags_en}, 3'b100);
      chk("R9", "flags", flags, 4'b0000);
    end
  endtask

  task automatic t_latency;
    apply(8'h03, 32'h2, 32'h3);
    chk("R10", "out_valid after accept", out_valid, 1'b1);
    @(posedge clk);
    #1;
    chk("R10", "idle out_valid/wr_en/flags_en/illegal",
        {out_valid, wr_en, flags_en, illegal}, 4'b0000);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_cmp();
    t_illegal();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule